// File: doc/BRIEF.md
# Key-Protected Slow Clock Source Selector

This block chooses the slow timekeeping reference for an always-on domain. Two sources are available: an internal RC oscillator and an external 32 kHz crystal. Both are modelled as one-cycle enable pulses on the system clock (`int_osc_tick`, `ext_osc_tick`). The internal source passes through a fixed divide stage and then a programmable divide-by-(N+1) stage. The external source passes through undivided. The chosen source comes out as a single-cycle enable, `slow_tick`. A second copy, `slow_out`, is gated by a software-controlled enable for use at an output pin.

Software reaches the block through a simple 32-bit register bus. Writes take effect in the cycle they are presented, and reads are combinational from the address. A stray write to the control register could silently switch the time base. For that reason, the control register only accepts a write whose upper half-word carries a fixed key.

The block also watches an oscillator-good indication. When the external crystal stops, the block falls back to the internal oscillator on its own, unless software has disabled that fallback.

Top module: `slowclk_selector`

## Requirements
- R1: The control register (byte address 0x00) takes a write only when write data bits 31:16 equal 0x16AA. A write with any other upper half-word leaves every control bit unchanged.
- R2: Reads return zero in every bit that no field occupies. In particular, bits 31:16 of a control-register read are always zero. Unmapped addresses read as zero.
- R3: Control bit 0 selects the source: 0 selects the divided internal oscillator, 1 selects the external oscillator ticks, passed through undivided.
- R4: Control bit 4 drives `ext_osc_enable`. While bit 4 is clear, external ticks never reach `slow_tick`, even when bit 0 selects the external source.
- R5: When control bit 15 is clear and `ext_osc_good` is low at a clock edge, control bit 0 is cleared at that edge. This overrides a keyed write in the same cycle.
- R6: When control bit 15 is set, a low `ext_osc_good` leaves control bit 0 unchanged.
- R7: The prescale register (byte address 0x08) holds N in bits 4:0 and is written without a key. The internal path produces one tick per 32*(N+1) internal oscillator ticks, counting from reset.
- R8: `slow_tick` is registered. It is high for exactly one cycle, in the cycle after the clock edge that sampled the qualifying source tick, and it uses the source selection that was in force before that edge.
- R9: Bit 0 of the gate register (byte address 0x60) gates the output: `slow_out` equals `slow_tick` while the bit is 1 and stays low while it is 0.
- R10: After reset, all control bits, N and the gate bit are zero, and `slow_tick`, `slow_out` and `ext_osc_enable` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| int_osc_tick | input | 1 | One-cycle pulse per internal RC oscillator period |
| ext_osc_tick | input | 1 | One-cycle pulse per external crystal period |
| ext_osc_good | input | 1 | External oscillator running indication |
| ext_osc_enable | output | 1 | Enable for the external oscillator |
| slow_tick | output | 1 | Selected slow clock enable |
| slow_out | output | 1 | Gated copy of `slow_tick` for the output pin |

## Verification
The bench targets the following corner cases:
- Writes to the control register with a near-miss key. A design that decoded fewer key bits, or none, would change the source.
- Keyed writes while the crystal is reported bad. A design that let the write win over the fallback would keep running from a dead oscillator.
- The divider at N = 0, N = 31 and with irregular internal tick spacing. A miscounted stage would show up as a wrong pulse count over a window.
- Writes of all-ones data. A design that echoed the key bits or unused bits on readback would fail.

The bench also checks that external ticks are blocked while the oscillator enable is clear, and that the output gate masks pulses that `slow_tick` still carries.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;

  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int KEY_W   = 16;

  localparam logic [KEY_W-1:0]  CTRL_KEY   = 16'h16AA;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PRESC = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_GATE  = 8'h60;

  localparam int SEL_BIT    = 0;
  localparam int EXTEN_BIT  = 4;
  localparam int BYPASS_BIT = 15;
  localparam int GATE_BIT   = 0;

  typedef struct packed {
    logic bypass;
    logic ext_en;
    logic sel;
  } ctrl_t;

endpackage

// File: rtl/slowclk_regs.sv
module slowclk_regs
  import slowclk_pkg::*;
#(
  parameter int PRESC_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 ext_osc_good,
  output ctrl_t                ctrl,
  output logic [PRESC_W-1:0]   presc_n,
  output logic                 out_gate
);

  ctrl_t              ctrl_d;
  logic [PRESC_W-1:0] presc_d;
  logic               gate_d;
  logic               key_ok;
  logic               wr_ctrl;
  logic               wr_presc;
  logic               wr_gate;
  logic               wdata_unused;

  assign key_ok   = (bus_wdata[BUS_W-1 -: KEY_W] == CTRL_KEY);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL) && key_ok;
  assign wr_presc = bus_wr && (bus_addr == ADDR_PRESC);
  assign wr_gate  = bus_wr && (bus_addr == ADDR_GATE);

  assign wdata_unused = ^bus_wdata;

  // next-state: keyed write first, then the oscillator fallback
  always_comb begin
    ctrl_d = ctrl;
    if (wr_ctrl) begin
      ctrl_d.sel    = bus_wdata[SEL_BIT];
      ctrl_d.ext_en = bus_wdata[EXTEN_BIT];
      ctrl_d.bypass = bus_wdata[BYPASS_BIT];
    end
    if (!ctrl_d.bypass && !ext_osc_good) begin
      ctrl_d.sel = 1'b0;
    end
  end

  always_comb begin
    presc_d = presc_n;
    if (wr_presc) begin
      presc_d = bus_wdata[PRESC_W-1:0];
    end
  end

  always_comb begin
    gate_d = out_gate;
    if (wr_gate) begin
      gate_d = bus_wdata[GATE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      presc_n  <= '0;
      out_gate <= 1'b0;
    end else begin
      ctrl     <= ctrl_d;
      presc_n  <= presc_d;
      out_gate <= gate_d;
    end
  end

  // read path: only defined fields, never the key
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[SEL_BIT]    = ctrl.sel;
        bus_rdata[EXTEN_BIT]  = ctrl.ext_en;
        bus_rdata[BYPASS_BIT] = ctrl.bypass;
      end
      ADDR_PRESC: bus_rdata[PRESC_W-1:0] = presc_n;
      ADDR_GATE:  bus_rdata[GATE_BIT]    = out_gate;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/slowclk_divider.sv
module slowclk_divider #(
  parameter int FIXED_DIV = 32,
  parameter int PRESC_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_tick,
  input  logic [PRESC_W-1:0] presc_n,
  output logic               div_tick
);

  logic               stage_tick;
  logic [PRESC_W-1:0] prog_q;
  logic [PRESC_W-1:0] prog_d;
  logic               prog_wrap;

  generate
    if (FIXED_DIV > 1) begin : g_fixed
      localparam int FIX_W = $clog2(FIXED_DIV);
      localparam logic [FIX_W-1:0] FIX_LAST = FIX_W'(FIXED_DIV - 1);
      logic [FIX_W-1:0] fix_q;
      logic [FIX_W-1:0] fix_d;

      always_comb begin
        fix_d = fix_q;
        if (src_tick) begin
          fix_d = (fix_q == FIX_LAST) ? '0 : fix_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fix_q <= '0;
        end else if (src_tick) begin
          fix_q <= fix_d;
        end
      end

      assign stage_tick = src_tick && (fix_q == FIX_LAST);
    end else begin : g_nofixed
      assign stage_tick = src_tick;
    end
  endgenerate

  // >= so that lowering N mid-count wraps at once
  assign prog_wrap = (prog_q >= presc_n);

  always_comb begin
    prog_d = prog_q;
    if (stage_tick) begin
      prog_d = prog_wrap ? '0 : prog_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (stage_tick) begin
      prog_q <= prog_d;
    end
  end

  assign div_tick = stage_tick && prog_wrap;

endmodule

// File: rtl/slowclk_output.sv
module slowclk_output (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_ext,
  input  logic ext_en,
  input  logic ext_tick,
  input  logic int_tick,
  input  logic gate,
  output logic slow_tick,
  output logic slow_out
);

  logic tick_d;

  always_comb begin
    if (sel_ext) begin
      tick_d = ext_tick && ext_en;
    end else begin
      tick_d = int_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_tick <= 1'b0;
    end else begin
      slow_tick <= tick_d;
    end
  end

  assign slow_out = slow_tick && gate;

endmodule

// File: rtl/slowclk_selector.sv
module slowclk_selector
  import slowclk_pkg::*;
#(
  parameter int FIXED_DIV = 32,
  parameter int PRESC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              int_osc_tick,
  input  logic              ext_osc_tick,
  input  logic              ext_osc_good,
  output logic              ext_osc_enable,
  output logic              slow_tick,
  output logic              slow_out
);

  ctrl_t              ctrl;
  logic [PRESC_W-1:0] presc_n;
  logic               out_gate;
  logic               int_div_tick;

  slowclk_regs #(.PRESC_W(PRESC_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ext_osc_good (ext_osc_good),
    .ctrl         (ctrl),
    .presc_n      (presc_n),
    .out_gate     (out_gate)
  );

  slowclk_divider #(.FIXED_DIV(FIXED_DIV), .PRESC_W(PRESC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (int_osc_tick),
    .presc_n  (presc_n),
    .div_tick (int_div_tick)
  );

  slowclk_output u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_ext   (ctrl.sel),
    .ext_en    (ctrl.ext_en),
    .ext_tick  (ext_osc_tick),
    .int_tick  (int_div_tick),
    .gate      (out_gate),
    .slow_tick (slow_tick),
    .slow_out  (slow_out)
  );

  assign ext_osc_enable = ctrl.ext_en;

endmodule

// File: rtl/slowclk_selector_chk.sv
module slowclk_selector_chk
  import slowclk_pkg::*;
#(
  parameter int FIXED_DIV = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        ext_osc_good,
  input logic        sel_q,
  input logic        ext_en_q,
  input logic        bypass_q,
  input logic        gate_q,
  input logic        int_div_tick,
  input logic        slow_tick,
  input logic        slow_out
);

  assert_nokey_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTRL && bus_wdata[31:16] != CTRL_KEY)
    |=> ($stable(ext_en_q) && $stable(bypass_q)));

  assert_key_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTRL) |-> (bus_rdata[31:16] == 16'h0000));

  assert_ext_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !ext_en_q) |=> !slow_tick);

  assert_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !bypass_q) |-> $past(ext_osc_good));

  assert_div_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((FIXED_DIV > 1) && int_div_tick) |=> !int_div_tick);

  assert_gate_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !slow_out);

endmodule

bind slowclk_selector slowclk_selector_chk #(.FIXED_DIV(FIXED_DIV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .ext_osc_good (ext_osc_good),
  .sel_q        (ctrl.sel),
  .ext_en_q     (ctrl.ext_en),
  .bypass_q     (ctrl.bypass),
  .gate_q       (out_gate),
  .int_div_tick (int_div_tick),
  .slow_tick    (slow_tick),
  .slow_out     (slow_out)
);

// File: tb/tb_slowclk_selector.sv
module tb_slowclk_selector;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        int_osc_tick;
  logic        ext_osc_tick;
  logic        ext_osc_good;
  logic        ext_osc_enable;
  logic        slow_tick;
  logic        slow_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int cnt_tick = 0;
  int cnt_out  = 0;

  // behavioural reference state
  bit m_sel, m_ext_en, m_bypass, m_gate, m_tick;
  int m_n, m_fix, m_prog;

  always #(CLK_PERIOD/2) clk = ~clk;

  slowclk_selector dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
    .ext_osc_good(ext_osc_good), .ext_osc_enable(ext_osc_enable),
    .slow_tick(slow_tick), .slow_out(slow_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(input logic [7:0] a);
    logic [31:0] r = 32'h0;
    if (a == 8'h00) begin
      r[0] = m_sel; r[4] = m_ext_en; r[15] = m_bypass;
    end else if (a == 8'h08) begin
      r = 32'(m_n);
    end else if (a == 8'h60) begin
      r[0] = m_gate;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_ext_en = 0; m_bypass = 0; m_gate = 0; m_tick = 0;
      m_n = 0; m_fix = 0; m_prog = 0;
    end else begin
      bit dtick;
      bit ntick;
      dtick = int_osc_tick && (m_fix == 31) && (m_prog >= m_n);
      ntick = m_sel ? (ext_osc_tick && m_ext_en) : dtick;
      if (int_osc_tick) begin
        if (m_fix == 31) begin
          m_fix = 0;
          if (m_prog >= m_n) m_prog = 0; else m_prog = m_prog + 1;
        end else begin
          m_fix = m_fix + 1;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 8'h00 && bus_wdata[31:16] == 16'h16AA) begin
          m_sel = bus_wdata[0]; m_ext_en = bus_wdata[4]; m_bypass = bus_wdata[15];
        end
        if (bus_addr == 8'h08) m_n = int'(bus_wdata[4:0]);
        if (bus_addr == 8'h60) m_gate = bus_wdata[0];
      end
      if (!m_bypass && !ext_osc_good) m_sel = 0;
      m_tick = ntick;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 slow_tick vs model", {31'h0, slow_tick}, {31'h0, m_tick});
      chk("R9 slow_out vs model", {31'h0, slow_out}, {31'h0, m_tick && m_gate});
      chk("R4 ext_osc_enable vs model", {31'h0, ext_osc_enable}, {31'h0, m_ext_en});
      chk("R2 bus_rdata vs model", bus_rdata, m_rdata(bus_addr));
      if (slow_tick) cnt_tick++;
      if (slow_out)  cnt_out++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic run(input int n, input int ie, input int ee);
    for (int i = 0; i < n; i++) begin
      int_osc_tick = (ie > 0) && (i % ie == 0);
      ext_osc_tick = (ee > 0) && (i % ee == 0);
      @(negedge clk); #1;
    end
    int_osc_tick = 1'b0; ext_osc_tick = 1'b0;
    repeat (2) begin @(negedge clk); #1; end
  endtask

  task automatic window(input int n, input int ie, input int ee,
                        input int exp_tick, input int exp_out, input string tag);
    int t0 = cnt_tick;
    int o0 = cnt_out;
    run(n, ie, ee);
    chk({tag, " tick count"}, 32'(cnt_tick - t0), 32'(exp_tick));
    chk({tag, " out count"}, 32'(cnt_out - o0), 32'(exp_out));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    int_osc_tick = 0; ext_osc_tick = 0; ext_osc_good = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    rd(8'h00, 32'h0, "R10 ctrl after reset");
    rd(8'h08, 32'h0, "R10 prescale after reset");
    rd(8'h60, 32'h0, "R10 gate after reset");
    chk("R10 outputs after reset", {29'h0, slow_tick, slow_out, ext_osc_enable}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R7 internal divide chain, R9 gate on
    wr(8'h60, 32'h1);
    rd(8'h08, 32'h0, "R7 prescale N=0");
    window(640, 1, 0, 20, 20, "R7 N=0 dense");
    wr(8'h08, 32'h3);
    rd(8'h08, 32'h3, "R7 prescale written without key");
    window(1024, 1, 0, 8, 8, "R7 N=3 dense");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h1F, "R2 R7 prescale reads only N");
    window(2048, 1, 0, 2, 2, "R7 N=31 dense");
    wr(8'h08, 32'h1);
    window(768, 3, 0, 4, 4, "R7 N=1 sparse");

    // R3 external selected, undivided
    wr(8'h00, 32'h16AA_0011);
    rd(8'h00, 32'h0000_0011, "R3 ctrl keyed write");
    chk("R4 ext_osc_enable set", {31'h0, ext_osc_enable}, 32'h1);
    window(100, 0, 5, 20, 20, "R3 R8 external passthrough");
    window(64, 1, 0, 0, 0, "R3 internal ignored when external selected");

    // R4 enable clear blocks ticks
    wr(8'h00, 32'h16AA_0001);
    chk("R4 ext_osc_enable clear", {31'h0, ext_osc_enable}, 32'h0);
    window(50, 0, 5, 0, 0, "R4 blocked without enable");

    // R1 wrong keys ignored
    wr(8'h00, 32'h1234_0000);
    rd(8'h00, 32'h0000_0001, "R1 foreign key ignored");
    wr(8'h00, 32'h16AB_0011);
    rd(8'h00, 32'h0000_0001, "R1 near-miss key ignored");

    // R5 fallback and its priority over a keyed write
    wr(8'h00, 32'h16AA_0011);
    ext_osc_good = 1'b0;
    @(negedge clk); #1;
    rd(8'h00, 32'h0000_0010, "R5 fallback to internal");
    wr(8'h00, 32'h16AA_0011);
    rd(8'h00, 32'h0000_0010, "R5 fallback beats keyed write");

    // R6 bypass holds selection
    wr(8'h00, 32'h16AA_8011);
    rd(8'h00, 32'h0000_8011, "R6 bypass keeps external");
    window(50, 0, 5, 10, 10, "R6 external ticks with bypass");

    // R9 gate off masks the output only
    wr(8'h60, 32'h0);
    window(50, 0, 5, 10, 0, "R9 gate closed");

    // R2 key and spare bits never read back
    wr(8'h00, 32'h16AA_FFFF);
    rd(8'h00, 32'h0000_8011, "R2 readback hides key and spare bits");
    rd(8'h44, 32'h0, "R2 unmapped address");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule